// File: doc/BRIEF.md
# Serial Asynchronous Receive Engine

This block turns an asynchronous serial line into bytes. Before anything else the raw input passes through a synchronizer. The receiver watches the line only while both the power input `pwr_en` and the receive enable `rx_en` are high.

A start bit is detected in two steps:
- A falling edge on the synchronized line starts a counter.
- When the counter reaches `start_cmp`, the line is sampled a second time. The start bit is accepted only if the line is still low at that point.

Once a start bit is accepted, the engine takes one sample per bit period, each `bit_period` clocks after the previous one. It collects eight data bits, least significant first. If parity is selected it then takes the parity slot, and finally a single stop bit. If a second stop bit is sent, it looks like idle line and is ignored.

When the stop bit is sampled, the byte goes into a holding register. The holding register is presented as a valid/ready output stream:
- `hold_valid` stays high until a cycle with `hold_ready` high accepts the byte.
- While `hold_valid` is high and `hold_ready` is low, `hold_data` does not change.
- The engine cannot stall the serial line, so back-pressure has a fixed outcome. If a new frame completes while the register is still unaccepted, the new byte is dropped and an overrun is reported.
- A byte accepted in the same cycle as a frame completes counts as read in time.

Every finished frame gives exactly one one-cycle pulse. The pulse is `rx_done` when the frame is clean and `rx_err` when there was a parity, framing or overrun error. The error flags hold their value until `err_clear` is pulsed.

Top module: `uart_rx_engine`

## Requirements
- R1: After reset, `busy`, `hold_valid`, `rx_done`, `rx_err`, `err_parity`, `err_frame` and `err_overrun` are all 0.
- R2: Unless `pwr_en` and `rx_en` are both 1, the receiver stays idle. Clearing either one returns it to idle, with `busy` low from the next cycle. A frame sent while disabled produces no pulse and leaves `hold_valid` unchanged.
- R3: A falling edge on the synchronized line starts a count, and the line is sampled again `start_cmp`+1 clocks later. If the line is high at that sample, the edge is discarded: `busy` never rises and no pulse is issued.
- R4: `busy` rises when the start bit is accepted and falls in the same cycle as the frame's `rx_done` or `rx_err` pulse.
- R5: Bits are sampled every `bit_period` clocks after start acceptance. The first 8 bits are data, least significant first, so `hold_data[0]` is the first data bit. `parity_mode` 2'b00 means no parity slot (the stop bit follows bit 7). Any other value inserts one parity slot before the stop bit.
- R6: At the stop sample, if the holding register is free or is being accepted that cycle, the byte is written and `hold_valid` becomes 1. In that same cycle either `rx_done` or `rx_err` pulses for exactly one clock, and never both.
- R7: When `hold_valid` and `hold_ready` are both 1 in a cycle, `hold_valid` is cleared (unless a new byte is written in that cycle). While `hold_valid` is 1 and `hold_ready` is 0, `hold_data` is held.
- R8: If a frame completes while `hold_valid` is 1 and `hold_ready` is 0, the byte is discarded and `err_overrun` is set. `rx_err` pulses and `rx_done` does not. A frame completing in the same cycle as an accepting read is not an overrun.
- R9: `parity_mode` 2'b10 means odd parity and 2'b11 means even parity; a mismatch sets `err_parity`. Mode 2'b01 has a parity slot that is not checked. A parity error does not stop the frame: the byte is still written and `rx_err` pulses instead of `rx_done`.
- R10: If the stop bit is sampled low, `err_frame` is set and `rx_err` pulses. The byte is still written.
- R11: `err_parity`, `err_frame` and `err_overrun` stay set until a cycle with `err_clear` high clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_en | input | 1 | Receiver power enable |
| rx_en | input | 1 | Receive enable |
| rxd | input | 1 | Asynchronous serial input, idle high |
| bit_period | input | BP_W (16) | Clocks per bit |
| start_cmp | input | CMP_W (8) | Count value at which the start bit is confirmed, normally half the bit period |
| parity_mode | input | 2 | 00 none, 01 unchecked slot, 10 odd, 11 even |
| hold_data | output | DATA_W (8) | Holding register contents |
| hold_valid | output | 1 | Holding register holds an unaccepted byte |
| hold_ready | input | 1 | Consumer accepts the byte when `hold_valid` is high |
| busy | output | 1 | Frame in progress |
| rx_done | output | 1 | One-cycle pulse: clean frame stored |
| rx_err | output | 1 | One-cycle pulse: frame finished with an error |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun |
| err_clear | input | 1 | Clears the sticky error flags |

## Verification
Two events can meet in a single cycle: the consumer accepting the held byte and the stop-bit sample of the next frame. The bench raises `hold_ready` for exactly the clock in which the stop sample happens, while the holding register still contains an earlier byte. This is correct when the new byte replaces the old one, `hold_valid` stays high, `rx_done` pulses and `err_overrun` stays clear. The same frame sent with `hold_ready` held low serves as the contrast: the old byte must remain and an overrun must be reported.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_PAR   = 3'd3,
    RX_STOP  = 3'd4
  } rx_state_t;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_SLOT = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_mode_t;

  // acc is the XOR of all data bits received; pbit is the parity slot value
  function automatic logic parity_mismatch(input par_mode_t mode,
                                           input logic acc,
                                           input logic pbit);
    logic ones_odd;
    ones_odd = acc ^ pbit;
    case (mode)
      PAR_ODD:  parity_mismatch = ~ones_odd;
      PAR_EVEN: parity_mismatch = ones_odd;
      default:  parity_mismatch = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic line,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain[i] <= 1'b1;
        end else begin
          if (i == 0) chain[i] <= din;
          else        chain[i] <= chain[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  assign line = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= line;
  end

  assign fall = prev & ~line;
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == limit);
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      line,
  input  logic      fall,
  input  logic      hit,
  input  par_mode_t par_mode,
  output logic      timer_clr,
  output logic      sel_start,
  output logic      frame_start,
  output logic      data_stb,
  output logic      par_stb,
  output logic      stop_stb,
  output logic      busy
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  rx_state_t        state, state_nx;
  logic [IDX_W-1:0] idx;

  always_comb begin
    state_nx    = state;
    frame_start = 1'b0;
    data_stb    = 1'b0;
    par_stb     = 1'b0;
    stop_stb    = 1'b0;
    case (state)
      RX_IDLE: begin
        if (fall) state_nx = RX_START;
      end
      RX_START: begin
        if (hit) begin
          if (!line) begin
            state_nx    = RX_DATA;
            frame_start = 1'b1;
          end else begin
            state_nx = RX_IDLE;
          end
        end
      end
      RX_DATA: begin
        if (hit) begin
          data_stb = 1'b1;
          if (idx == LAST_IDX)
            state_nx = (par_mode == PAR_NONE) ? RX_STOP : RX_PAR;
        end
      end
      RX_PAR: begin
        if (hit) begin
          par_stb  = 1'b1;
          state_nx = RX_STOP;
        end
      end
      RX_STOP: begin
        if (hit) begin
          stop_stb = 1'b1;
          state_nx = RX_IDLE;
        end
      end
      default: state_nx = RX_IDLE;
    endcase
    if (!enable) begin
      state_nx    = RX_IDLE;
      frame_start = 1'b0;
      data_stb    = 1'b0;
      par_stb     = 1'b0;
      stop_stb    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      idx   <= '0;
    end else begin
      state <= state_nx;
      if (frame_start)   idx <= '0;
      else if (data_stb) idx <= idx + 1'b1;
    end
  end

  assign timer_clr = (state == RX_IDLE) || hit || !enable;
  assign sel_start = (state == RX_START);
  assign busy      = (state != RX_IDLE) && (state != RX_START);
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              data_stb,
  input  logic              par_stb,
  input  logic              bit_in,
  input  par_mode_t         par_mode,
  output logic [DATA_W-1:0] data,
  output logic              par_bad
);
  logic acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data    <= '0;
      acc     <= 1'b0;
      par_bad <= 1'b0;
    end else if (frame_start) begin
      acc     <= 1'b0;
      par_bad <= 1'b0;
    end else if (data_stb) begin
      data <= {bit_in, data[DATA_W-1:1]};
      acc  <= acc ^ bit_in;
    end else if (par_stb) begin
      par_bad <= parity_mismatch(par_mode, acc, bit_in);
    end
  end
endmodule

// File: rtl/rx_hold_stage.sv
module rx_hold_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_stb,
  input  logic              stop_bit,
  input  logic [DATA_W-1:0] shift_data,
  input  logic              par_bad,
  input  logic              hold_ready,
  input  logic              err_clear,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_valid,
  output logic              rx_done,
  output logic              rx_err,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun
);
  logic accept, ovr_ev, write_ev, pe_ev, fe_ev, bad_ev;

  assign accept   = hold_valid & hold_ready;
  assign ovr_ev   = stop_stb & hold_valid & ~hold_ready;
  assign write_ev = stop_stb & ~ovr_ev;
  assign pe_ev    = stop_stb & par_bad;
  assign fe_ev    = stop_stb & ~stop_bit;
  assign bad_ev   = ovr_ev | pe_ev | fe_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data   <= '0;
      hold_valid  <= 1'b0;
      rx_done     <= 1'b0;
      rx_err      <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      if (write_ev) begin
        hold_data  <= shift_data;
        hold_valid <= 1'b1;
      end else if (accept) begin
        hold_valid <= 1'b0;
      end
      rx_done     <= stop_stb & ~bad_ev;
      rx_err      <= bad_ev;
      err_parity  <= pe_ev  | (err_parity  & ~err_clear);
      err_frame   <= fe_ev  | (err_frame   & ~err_clear);
      err_overrun <= ovr_ev | (err_overrun & ~err_clear);
    end
  end
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BP_W        = 16,
  parameter int CMP_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_en,
  input  logic              rx_en,
  input  logic              rxd,
  input  logic [BP_W-1:0]   bit_period,
  input  logic [CMP_W-1:0]  start_cmp,
  input  logic [1:0]        parity_mode,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_valid,
  input  logic              hold_ready,
  output logic              busy,
  output logic              rx_done,
  output logic              rx_err,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  input  logic              err_clear
);
  localparam int TW = (BP_W > CMP_W) ? BP_W : CMP_W;

  logic              line, fall, hit, enable;
  logic              timer_clr, sel_start, frame_start;
  logic              data_stb, par_stb, stop_stb, par_bad;
  logic [TW-1:0]     limit;
  logic [DATA_W-1:0] shift_data;
  par_mode_t         pmode;

  assign enable = pwr_en & rx_en;
  assign pmode  = par_mode_t'(parity_mode);
  assign limit  = sel_start ? TW'(start_cmp) : (TW'(bit_period) - TW'(1));

  rx_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .din(rxd), .line(line), .fall(fall)
  );

  rx_bit_timer #(.W(TW)) timer_i (
    .clk(clk), .rst_n(rst_n), .clr(timer_clr), .limit(limit), .hit(hit)
  );

  rx_frame_fsm #(.DATA_W(DATA_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .line(line), .fall(fall),
    .hit(hit), .par_mode(pmode), .timer_clr(timer_clr), .sel_start(sel_start),
    .frame_start(frame_start), .data_stb(data_stb), .par_stb(par_stb),
    .stop_stb(stop_stb), .busy(busy)
  );

  rx_shifter #(.DATA_W(DATA_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .data_stb(data_stb),
    .par_stb(par_stb), .bit_in(line), .par_mode(pmode), .data(shift_data),
    .par_bad(par_bad)
  );

  rx_hold_stage #(.DATA_W(DATA_W)) hold_i (
    .clk(clk), .rst_n(rst_n), .stop_stb(stop_stb), .stop_bit(line),
    .shift_data(shift_data), .par_bad(par_bad), .hold_ready(hold_ready),
    .err_clear(err_clear), .hold_data(hold_data), .hold_valid(hold_valid),
    .rx_done(rx_done), .rx_err(rx_err), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun)
  );
endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_en,
  input logic              rx_en,
  input logic              busy,
  input logic [DATA_W-1:0] hold_data,
  input logic              hold_valid,
  input logic              hold_ready,
  input logic              rx_done,
  input logic              rx_err,
  input logic              err_overrun,
  input logic              err_frame,
  input logic              err_clear
);
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_en && rx_en) |=> !busy); // R2

  AST_PULSE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done || rx_err) |-> ($past(busy) && !busy)); // R4

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_done && rx_err)); // R6

  AST_DONE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> hold_valid); // R6

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_valid && !hold_ready) |=> $stable(hold_data)); // R7

  AST_ACCEPT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_valid && hold_ready) |=> (!hold_valid || rx_done || rx_err)); // R7

  AST_OVERRUN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> rx_err); // R8

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_overrun && !err_clear) |=> err_overrun); // R11

  AST_FRAME_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frame && !err_clear) |=> err_frame); // R11
endmodule

bind uart_rx_engine uart_rx_checker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .rx_en(rx_en), .busy(busy),
  .hold_data(hold_data), .hold_valid(hold_valid), .hold_ready(hold_ready),
  .rx_done(rx_done), .rx_err(rx_err), .err_overrun(err_overrun),
  .err_frame(err_frame), .err_clear(err_clear)
);

// File: tb/uart_rx_engine_tb_top.sv
`timescale 1ns/1ps
module uart_rx_engine_tb_top;
  localparam int BP  = 16;
  localparam int CMP = 7;
  localparam int NV  = 9;
  // {data[7:0], mode[1:0], flip_parity, bad_stop, exp_parity_err, exp_frame_err}
  localparam logic [13:0] VEC [NV] = '{
    {8'hA5, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h3C, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h81, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h7E, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h55, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h0F, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'hF0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'hFF, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'h00, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_en = 1'b0, rx_en = 1'b0, rxd = 1'b1;
  logic hold_ready = 1'b0, err_clear = 1'b0;
  logic [1:0] parity_mode = 2'b00;
  logic [15:0] bit_period = 16'(BP);
  logic [7:0]  start_cmp = 8'(CMP);
  logic [7:0]  hold_data;
  logic hold_valid, busy, rx_done, rx_err, err_parity, err_frame, err_overrun;

  int checks = 0, errors = 0;
  int n_done = 0, n_err = 0, n_rise = 0;
  logic busy_q = 1'b0;
  logic busy_mid, busy_end;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  uart_rx_engine dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .rx_en(rx_en), .rxd(rxd),
    .bit_period(bit_period), .start_cmp(start_cmp), .parity_mode(parity_mode),
    .hold_data(hold_data), .hold_valid(hold_valid), .hold_ready(hold_ready),
    .busy(busy), .rx_done(rx_done), .rx_err(rx_err), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun), .err_clear(err_clear)
  );

  always @(negedge clk) begin
    if (rx_done) n_done <= n_done + 1;
    if (rx_err)  n_err  <= n_err + 1;
    if (busy && !busy_q) n_rise <= n_rise + 1;
    busy_q <= busy;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [1:0] m,
                            input bit flip, input bit bad_stop, input bit collide);
    logic [10:0] fr;
    logic p;
    int nb, stopc;
    nb = (m == 2'b00) ? 10 : 11;
    p = (m == 2'b10) ? ~^d : ((m == 2'b11) ? ^d : 1'b0);
    fr = '1;
    fr[0] = 1'b0;
    fr[8:1] = d;
    if (m != 2'b00) fr[9] = p ^ flip;
    fr[nb-1] = ~bad_stop;
    stopc = 10 + (nb - 1) * BP;
    for (int c = 0; c < nb * BP; c++) begin
      rxd = fr[c / BP];
      if (collide) hold_ready = (c == stopc);
      if (c == 80) busy_mid = busy;
      if (c == stopc + 2) busy_end = busy;
      @(negedge clk);
    end
    rxd = 1'b1;
    hold_ready = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic read_hold();
    hold_ready = 1'b1;
    @(negedge clk);
    hold_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_flags();
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int d0, e0, r0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({busy, hold_valid, rx_done, rx_err, err_parity, err_frame, err_overrun} == 7'b0,
          "R1 reset outputs", {busy, hold_valid, rx_done, rx_err, err_parity, err_frame, err_overrun}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: disabled receiver ignores a frame
    pwr_en = 1'b1; rx_en = 1'b0;
    r0 = n_rise; d0 = n_done; e0 = n_err;
    send_frame(8'h5A, 2'b00, 1'b0, 1'b0, 1'b0);
    check(n_rise == r0 && n_done == d0 && n_err == e0 && !hold_valid,
          "R2 rx_en low ignored", n_rise - r0 + n_done - d0 + n_err - e0, 0);
    pwr_en = 1'b0; rx_en = 1'b1;
    send_frame(8'h5A, 2'b00, 1'b0, 1'b0, 1'b0);
    check(n_rise == r0 && n_done == d0 && !hold_valid,
          "R2 pwr_en low ignored", n_rise - r0 + n_done - d0, 0);
    pwr_en = 1'b1;
    @(negedge clk);

    // R3: short glitch rejected
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    check(n_rise == r0 && n_done == d0 && n_err == e0, "R3 glitch rejected", n_rise - r0, 0);

    // Table walk: R5 R6 R7 R9 R10
    for (int v = 0; v < NV; v++) begin
      logic [7:0] d;
      logic [1:0] m;
      d = VEC[v][13:6];
      m = VEC[v][5:4];
      parity_mode = m;
      clear_flags();
      d0 = n_done; e0 = n_err;
      send_frame(d, m, VEC[v][3], VEC[v][2], 1'b0);
      check(busy_mid == 1'b1, "R4 busy mid frame", busy_mid, 1);
      check(busy_end == 1'b0, "R4 busy after stop", busy_end, 0);
      check(hold_data == d, "R5 data LSB first", hold_data, d);
      check(hold_valid == 1'b1, "R6 valid after frame", hold_valid, 1);
      if (VEC[v][1] || VEC[v][0]) begin
        check(n_err - e0 == 1 && n_done == d0, "R9 R10 error pulse", n_err - e0, 1);
      end else begin
        check(n_done - d0 == 1 && n_err == e0, "R6 done pulse", n_done - d0, 1);
      end
      check(err_parity == VEC[v][1], "R9 parity flag", err_parity, VEC[v][1]);
      check(err_frame == VEC[v][0], "R10 frame flag", err_frame, VEC[v][0]);
      read_hold();
      check(hold_valid == 1'b0, "R7 accept clears valid", hold_valid, 0);
    end

    // R11: sticky flag clears on err_clear
    parity_mode = 2'b00;
    send_frame(8'h99, 2'b00, 1'b0, 1'b1, 1'b0);
    repeat (30) @(negedge clk);
    check(err_frame == 1'b1, "R11 flag sticky", err_frame, 1);
    clear_flags();
    check(err_frame == 1'b0, "R11 flag cleared", err_frame, 0);
    read_hold();

    // R8: overrun keeps old byte
    send_frame(8'h11, 2'b00, 1'b0, 1'b0, 1'b0);
    d0 = n_done; e0 = n_err;
    send_frame(8'h22, 2'b00, 1'b0, 1'b0, 1'b0);
    check(hold_data == 8'h11, "R8 old byte kept", hold_data, 8'h11);
    check(err_overrun == 1'b1, "R8 overrun flag", err_overrun, 1);
    check(n_err - e0 == 1 && n_done == d0, "R8 error pulse", n_err - e0, 1);
    check(hold_valid == 1'b1, "R7 valid held", hold_valid, 1);

    // R8: accept in the stop-sample cycle is not an overrun
    clear_flags();
    d0 = n_done; e0 = n_err;
    send_frame(8'h33, 2'b00, 1'b0, 1'b0, 1'b1);
    check(hold_data == 8'h33, "R8 collision new byte", hold_data, 8'h33);
    check(hold_valid == 1'b1, "R8 collision valid", hold_valid, 1);
    check(err_overrun == 1'b0, "R8 collision no overrun", err_overrun, 0);
    check(n_done - d0 == 1 && n_err == e0, "R8 collision done pulse", n_done - d0, 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule